// File: doc/BRIEF.md
# GPIB Talker Handshake with Programmable Settling Delay

This block drives the talker side of a GPIB byte transfer. The host writes a byte, with an optional end flag, and the block places it on the data lines. It then waits a programmable settling time before raising DAV. Once a listener has accepted the byte (NDAC false), the block drops DAV and reports that it can take the next byte. Listener logic, controller functions and the bus transceivers sit outside the block.

The settling time comes from a preset N, loaded through an auxiliary command port. A normal transfer waits 2·N clocks, so N set to the clock rate in MHz gives 2 µs. An optional fast mode keeps the full wait for the first byte after ATN is released and uses about a quarter of it for every later byte. Two optional holdoffs keep DAV low until the host pulses a release strobe: one applies to every byte, the other only to end bytes. The block keeps an end-of-string byte. It compares each outgoing byte with it, on 7 or 8 bits, and can raise EOI automatically on a match.

Top module: `gpib_src_hs`

## Requirements
- R1: An auxiliary write of 0x2n (upper nibble 0010) sets the preset N to the low nibble. A value of 0 is stored as 1 and a value above 8 is stored as 8. After reset N is 8.
- R2: With fast mode off, DAV rises exactly 2·N clock edges after the edge on which the written byte appears on `dio`. `dio` stays unchanged while DAV is high.
- R3: An auxiliary write of 0b1010_bbbb sets fast mode from bit 2. In fast mode, the first byte accepted after reset, or after ATN has been true, waits 2·N edges. Every later byte waits ceil(N/2) edges, so N=3 gives 2 and N=5 gives 3.
- R4: An auxiliary write of 0b100a_aaaa loads the option bits: bit 0 hold-all, bit 1 hold-end, bit 3 EOI-on-match, bit 4 8-bit compare. Bit 2 is ignored. With hold-all set, DAV stays low for every byte until a `fin_hs` pulse has been sampled. DAV then rises on the following edge if the delay has elapsed and NRFD is false.
- R5: With only hold-end set, a byte is held off as in R4 only if it is written with `wr_eoi` or if it matches the end-of-string byte. Other bytes are not held.
- R6: `eos_wr` loads the end-of-string byte. `eoi` is driven high together with a byte written with `wr_eoi`, or with a matching byte when EOI-on-match is set. It goes low when the handshake completes.
- R7: With 8-bit compare clear, a match needs only bits 6..0 equal. With it set, all 8 bits must be equal.
- R8: DAV rises only on an edge where NRFD is sampled false. While NRFD is true after the delay, DAV waits.
- R9: While DAV is high, the first edge that samples NDAC false drops DAV and raises `ready`.
- R10: A byte write while a byte is in flight (`ready` low) is ignored and leaves `dio` unchanged. It sets `err`, which stays set until reset.
- R11: After reset `dav`, `eoi` and `err` are low, `ready` is high and `dio` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Host byte write strobe |
| wr_data | input | DATA_W | Byte to send |
| wr_eoi | input | 1 | Send the byte with EOI |
| aux_wr | input | 1 | Auxiliary command strobe |
| aux_data | input | 8 | Auxiliary command word |
| eos_wr | input | 1 | End-of-string byte load strobe |
| eos_data | input | DATA_W | End-of-string byte |
| fin_hs | input | 1 | Holdoff release strobe |
| atn | input | 1 | ATN line, 1 = true |
| nrfd | input | 1 | NRFD line, 1 = true |
| ndac | input | 1 | NDAC line, 1 = true |
| dio | output | DATA_W | Data lines |
| dav | output | 1 | DAV, 1 = true |
| eoi | output | 1 | EOI, 1 = true |
| ready | output | 1 | Ready for the next byte |
| err | output | 1 | Sticky write-while-busy flag |

## Verification
The bench uses the default parameters: 8-bit data, and a preset that can range from 1 to 8 and resets to 8. The small preset range lets the bench measure every wait edge by edge, from the 16-edge reset default down to a single edge. The odd presets 3 and 5 exercise the rounding of the fast wait. Pulsing ATN between bytes shows that the full first-byte delay is armed again.

// File: rtl/gpib_src_pkg.sv
package gpib_src_pkg;

    localparam int AUX_W = 8;

    // Auxiliary command opcodes (upper bits of the command word)
    localparam logic [3:0] OP_PRESET = 4'b0010;
    localparam logic [2:0] OP_OPTS   = 3'b100;
    localparam logic [3:0] OP_SPEED  = 4'b1010;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_DAV
    } src_state_e;

    typedef struct packed {
        logic bin_cmp;
        logic eoi_on_eos;
        logic hold_end;
        logic hold_all;
        logic fast;
    } src_feat_t;

    function automatic int unsigned clamp_preset(input int unsigned raw,
                                                 input int unsigned nmax);
        if (raw == 0)
            return 1;
        if (raw > nmax)
            return nmax;
        return raw;
    endfunction

endpackage

// File: rtl/gpib_aux_regs.sv
module gpib_aux_regs
    import gpib_src_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int N_MAX   = 8,
    parameter int N_RESET = 8,
    localparam int PRE_W  = $clog2(N_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              aux_wr,
    input  logic [AUX_W-1:0]  aux_data,
    input  logic              eos_wr,
    input  logic [DATA_W-1:0] eos_data,
    output logic [PRE_W-1:0]  preset,
    output src_feat_t         feat,
    output logic [DATA_W-1:0] eos
);

    always_ff @(posedge clk) begin
        if (rst) begin
            preset <= PRE_W'(clamp_preset(N_RESET, N_MAX));
            feat   <= '0;
        end else if (aux_wr) begin
            if (aux_data[7:4] == OP_PRESET)
                preset <= PRE_W'(clamp_preset(int'(aux_data[3:0]), N_MAX));
            else if (aux_data[7:5] == OP_OPTS) begin
                feat.hold_all   <= aux_data[0];
                feat.hold_end   <= aux_data[1];
                feat.eoi_on_eos <= aux_data[3];
                feat.bin_cmp    <= aux_data[4];
            end else if (aux_data[7:4] == OP_SPEED)
                feat.fast <= aux_data[2];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            eos <= '0;
        else if (eos_wr)
            eos <= eos_data;
    end

endmodule

// File: rtl/gpib_settle_timer.sv
module gpib_settle_timer #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - CNT_W'(1);
    end

    assign done = (cnt == '0);

endmodule

// File: rtl/gpib_src_hs.sv
module gpib_src_hs
    import gpib_src_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int N_MAX   = 8,
    parameter int N_RESET = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_eoi,
    input  logic              aux_wr,
    input  logic [AUX_W-1:0]  aux_data,
    input  logic              eos_wr,
    input  logic [DATA_W-1:0] eos_data,
    input  logic              fin_hs,
    input  logic              atn,
    input  logic              nrfd,
    input  logic              ndac,
    output logic [DATA_W-1:0] dio,
    output logic              dav,
    output logic              eoi,
    output logic              ready,
    output logic              err
);

    localparam int PRE_W = $clog2(N_MAX + 1);
    localparam int CNT_W = $clog2(2 * N_MAX + 1);

    logic [PRE_W-1:0]  preset;
    src_feat_t         feat;
    logic [DATA_W-1:0] eos;

    src_state_e        state;
    logic [DATA_W-1:0] dio_q;
    logic              eoi_q, hold_q, first_q, err_q;

    logic              accept, is_match, eoi_next, hold_next, use_full, tmr_done;
    logic [DATA_W-1:0] cmp_mask;
    logic [CNT_W-1:0]  pre_ext, full_len, fast_len, len, load_val;

    gpib_aux_regs #(
        .DATA_W (DATA_W),
        .N_MAX  (N_MAX),
        .N_RESET(N_RESET)
    ) u_aux (
        .clk     (clk),
        .rst     (rst),
        .aux_wr  (aux_wr),
        .aux_data(aux_data),
        .eos_wr  (eos_wr),
        .eos_data(eos_data),
        .preset  (preset),
        .feat    (feat),
        .eos     (eos)
    );

    gpib_settle_timer #(
        .CNT_W(CNT_W)
    ) u_tmr (
        .clk     (clk),
        .rst     (rst),
        .load    (accept),
        .load_val(load_val),
        .done    (tmr_done)
    );

    // Byte classification and settling length, taken at write time
    always_comb begin
        accept    = wr_en && (state == ST_IDLE);
        cmp_mask  = feat.bin_cmp ? '1 : {1'b0, {(DATA_W-1){1'b1}}};
        is_match  = ((wr_data ^ eos) & cmp_mask) == '0;
        eoi_next  = wr_eoi | (feat.eoi_on_eos & is_match);
        hold_next = feat.hold_all | (feat.hold_end & (wr_eoi | is_match));
        use_full  = !feat.fast || first_q || atn;
        pre_ext   = CNT_W'(preset);
        full_len  = pre_ext << 1;
        fast_len  = (pre_ext + CNT_W'(1)) >> 1;
        len       = use_full ? full_len : fast_len;
        load_val  = len - CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            dio_q  <= '0;
            eoi_q  <= 1'b0;
            hold_q <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (accept) begin
                        state  <= ST_SETTLE;
                        dio_q  <= wr_data;
                        eoi_q  <= eoi_next;
                        hold_q <= hold_next;
                    end
                end
                ST_SETTLE: begin
                    if (fin_hs)
                        hold_q <= 1'b0;
                    if (tmr_done && !hold_q && !nrfd)
                        state <= ST_DAV;
                end
                ST_DAV: begin
                    if (!ndac) begin
                        state <= ST_IDLE;
                        eoi_q <= 1'b0;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // First-byte marker: armed by reset and while ATN is true
    always_ff @(posedge clk) begin
        if (rst)
            first_q <= 1'b1;
        else if (atn)
            first_q <= 1'b1;
        else if (accept)
            first_q <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)
            err_q <= 1'b0;
        else if (wr_en && state != ST_IDLE)
            err_q <= 1'b1;
    end

    assign dio   = dio_q;
    assign eoi   = eoi_q;
    assign dav   = (state == ST_DAV);
    assign ready = (state == ST_IDLE);
    assign err   = err_q;

endmodule

// File: rtl/gpib_src_hs_checker.sv
module gpib_src_hs_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic              nrfd,
    input logic              ndac,
    input logic [DATA_W-1:0] dio,
    input logic              dav,
    input logic              eoi,
    input logic              ready,
    input logic              err
);

    p_dav_after_rfd_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(dav) |-> $past(!nrfd));

    p_dio_hold_r2: assert property (@(posedge clk) disable iff (rst)
        dav |-> $stable(dio));

    p_settle_first_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(dav) |-> $past(!ready));

    p_release_r9: assert property (@(posedge clk) disable iff (rst)
        (dav && !ndac) |=> (!dav && ready));

    p_busy_ignored_r10: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !ready) |=> ($stable(dio) && err));

    p_err_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        err |=> err);

    p_reset_state_r11: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!dav && !eoi && ready && !err && dio == '0));

endmodule

bind gpib_src_hs gpib_src_hs_checker #(.DATA_W(DATA_W)) u_chk (
    .clk  (clk),
    .rst  (rst),
    .wr_en(wr_en),
    .nrfd (nrfd),
    .ndac (ndac),
    .dio  (dio),
    .dav  (dav),
    .eoi  (eoi),
    .ready(ready),
    .err  (err)
);

// File: tb/gpib_src_hs_bench.sv
module gpib_src_hs_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0, wr_eoi = 1'b0, aux_wr = 1'b0, eos_wr = 1'b0;
    logic [7:0] wr_data = '0, aux_data = '0, eos_data = '0;
    logic       fin_hs = 1'b0, atn = 1'b0, nrfd = 1'b0, ndac = 1'b1;
    logic [7:0] dio;
    logic       dav, eoi, ready, err;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    always #4 clk = ~clk;

    gpib_src_hs u_gpib_src_hs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .wr_eoi(wr_eoi),
        .aux_wr(aux_wr), .aux_data(aux_data), .eos_wr(eos_wr), .eos_data(eos_data),
        .fin_hs(fin_hs), .atn(atn), .nrfd(nrfd), .ndac(ndac),
        .dio(dio), .dav(dav), .eoi(eoi), .ready(ready), .err(err)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles, expected below 20000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic aux_cmd(input logic [7:0] w);
        @(negedge clk); aux_wr = 1'b1; aux_data = w;
        @(negedge clk); aux_wr = 1'b0;
    endtask

    task automatic load_eos(input logic [7:0] b);
        @(negedge clk); eos_wr = 1'b1; eos_data = b;
        @(negedge clk); eos_wr = 1'b0;
    endtask

    task automatic send(input logic [7:0] b, input logic e);
        @(negedge clk); wr_en = 1'b1; wr_data = b; wr_eoi = e;
        @(negedge clk); wr_en = 1'b0; wr_eoi = 1'b0;
    endtask

    task automatic wait_dav(output int n);
        n = 0;
        while (!dav && n < 64) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic ack(input string req);
        ndac = 1'b0;
        @(negedge clk);
        check({req, " dav low after ack"}, dav, 0);
        check({req, " ready after ack"}, ready, 1);
        ndac = 1'b1;
    endtask

    task automatic pulse_atn();
        @(negedge clk); atn = 1'b1;
        @(negedge clk); @(negedge clk); atn = 1'b0;
    endtask

    task automatic expect_delay(input string req, input logic [7:0] b, input int exp);
        int n;
        send(b, 1'b0);
        check({req, " dio"}, dio, b);
        wait_dav(n);
        check({req, " delay"}, n, exp);
        ack("R9");
    endtask

    task automatic expect_held(input string req, input logic [7:0] b, input logic e);
        send(b, e);
        repeat (20) @(negedge clk);
        check({req, " held"}, dav, 0);
        fin_hs = 1'b1;
        @(negedge clk); fin_hs = 1'b0;
        check({req, " not yet"}, dav, 0);
        @(negedge clk);
        check({req, " released"}, dav, 1);
        ack("R9");
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R11 dav", dav, 0);
        check("R11 eoi", eoi, 0);
        check("R11 ready", ready, 1);
        check("R11 err", err, 0);
        check("R11 dio", dio, 0);
    endtask

    task automatic t_preset();
        expect_delay("R1 reset N=8", 8'h5A, 16);
        aux_cmd(8'h23);
        expect_delay("R2 N=3", 8'h55, 6);
        aux_cmd(8'h20);
        expect_delay("R1 N=0 clamps to 1", 8'hA5, 2);
        aux_cmd(8'h2F);
        expect_delay("R1 N=15 clamps to 8", 8'h3C, 16);
        aux_cmd(8'h27);
        expect_delay("R2 N=7", 8'hC3, 14);
    endtask

    task automatic t_fast();
        aux_cmd(8'h25);
        aux_cmd(8'hA4);
        pulse_atn();
        expect_delay("R3 first after ATN N=5", 8'h01, 10);
        expect_delay("R3 later N=5", 8'h02, 3);
        aux_cmd(8'h23);
        expect_delay("R3 later N=3 rounds up", 8'h03, 2);
        aux_cmd(8'h21);
        expect_delay("R3 later N=1 rounds up", 8'h04, 1);
        aux_cmd(8'h23);
        pulse_atn();
        expect_delay("R3 rearmed by ATN N=3", 8'h05, 6);
        aux_cmd(8'hA0);
        expect_delay("R3 fast off", 8'h06, 6);
    endtask

    task automatic t_nrfd();
        aux_cmd(8'h22);
        nrfd = 1'b1;
        send(8'h77, 1'b0);
        repeat (10) @(negedge clk);
        check("R8 waits for NRFD false", dav, 0);
        nrfd = 1'b0;
        @(negedge clk);
        check("R8 dav after NRFD false", dav, 1);
        ack("R9");
    endtask

    task automatic t_hold();
        aux_cmd(8'h85);  // hold-all, with bit 2 set to show it is ignored
        expect_held("R4 hold-all", 8'h10, 1'b0);
        aux_cmd(8'h82);
        load_eos(8'h0D);
        expect_delay("R5 plain byte not held", 8'h41, 4);
        expect_held("R5 byte with EOI held", 8'h42, 1'b1);
        expect_held("R5 EOS byte held", 8'h0D, 1'b0);
        aux_cmd(8'h80);
    endtask

    task automatic t_eos();
        int n;
        load_eos(8'h8A);
        aux_cmd(8'h88);
        send(8'h0A, 1'b0);
        check("R7 7-bit match raises eoi", eoi, 1);
        wait_dav(n);
        ack("R9");
        check("R6 eoi cleared after handshake", eoi, 0);
        send(8'h0B, 1'b0);
        check("R6 no match no eoi", eoi, 0);
        wait_dav(n);
        ack("R9");
        send(8'h0B, 1'b1);
        check("R6 wr_eoi drives eoi", eoi, 1);
        wait_dav(n);
        ack("R9");
        aux_cmd(8'h98);
        send(8'h0A, 1'b0);
        check("R7 8-bit mismatch no eoi", eoi, 0);
        wait_dav(n);
        ack("R9");
        send(8'h8A, 1'b0);
        check("R7 8-bit match eoi", eoi, 1);
        wait_dav(n);
        ack("R9");
        aux_cmd(8'h80);
    endtask

    task automatic t_busy();
        int n;
        send(8'h11, 1'b0);
        wait_dav(n);
        check("R10 dav up before second write", dav, 1);
        send(8'h22, 1'b1);
        check("R10 dio unchanged", dio, 8'h11);
        check("R10 err set", err, 1);
        ack("R9");
        repeat (3) @(negedge clk);
        check("R10 err sticky", err, 1);
        check("R10 dio keeps first byte", dio, 8'h11);
    endtask

    initial begin
        t_reset();
        t_preset();
        t_fast();
        t_nrfd();
        t_hold();
        t_eos();
        t_busy();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule